// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

This block collects maskable interrupt requests from a fixed number of peripheral sources and decides which one, if any, is offered to the processor. Each source owns an 8-bit control register on a byte-wide register port. The register holds a 3-bit priority level and a pending-request flag. A peripheral sets its flag with a single-cycle pulse. Software can clear a flag but cannot set one.

Every cycle the block looks for the pending source with the highest level that is above the processor's current priority level. When the global enable input is high and such a source exists, the block raises its interrupt line and reports that source's index and level. An acknowledge pulse from the processor retires the reported request.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, every control register reads 0x00 and `irq` is low.
- R2: A write stores `reg_wdata[2:0]` as the addressed source's level. A read returns the level in bits 2..0 and the request flag in bit 3. Bits 7..4 always read 0, and writes to them have no effect.
- R3: A source whose level is 0 never wins and never causes `irq`, even when its request flag is 1.
- R4: Writing 0 to bit 3 clears the addressed flag. Writing 1 to bit 3 leaves the flag unchanged.
- R5: A source is eligible when its flag is 1 and its level is strictly greater than `cpu_lvl`. `irq` is 1 exactly when `glb_en` is 1 and at least one source is eligible.
- R6: Among the eligible sources, the one with the highest level wins. When levels tie, the lowest source index wins.
- R7: A high bit in `src_req` sets that source's flag at the next clock edge. The set takes priority over a software clear or an acknowledge in the same cycle.
- R8: An `ack` while `irq` is 1 clears only the flag of the source shown on `win_idx` in that cycle. An `ack` while `irq` is 0 changes nothing.
- R9: `win_idx` and `win_lvl` show the winning eligible source whatever the state of `glb_en`. Both are 0 when no source is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Source index selecting a control register |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the addressed register (combinational) |
| src_req | input | NSRC | Request pulses from the peripherals, one bit per source |
| glb_en | input | 1 | Global maskable-interrupt enable |
| cpu_lvl | input | 3 | Current processor priority level |
| ack | input | 1 | Processor acknowledge of the reported interrupt |
| irq | output | 1 | Interrupt request to the processor |
| win_idx | output | AW | Index of the winning source |
| win_lvl | output | 3 | Level of the winning source |

## Verification
The embedded assertions run on every cycle and cover the flag-update rules:
- a request pulse always leaves its flag set;
- a write of 1 to an idle flag never sets it;
- an acknowledge empties the reported source;
- a raised `irq` always points at a source that is pending, has a nonzero level and is above `cpu_lvl`.

Only the bench scenarios can show the choice between competing sources: the highest-level selection, the lowest-index tie-break, the zero outputs when nothing is eligible, and the register read-back format. The bench checks these against a reference model under random traffic and in directed cases.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC = 16,
  parameter int AW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NSRC-1:0] src_req,
  input  logic            glb_en,
  input  logic [2:0]      cpu_lvl,
  input  logic            ack,
  output logic            irq,
  output logic [AW-1:0]   win_idx,
  output logic [2:0]      win_lvl
);

  logic [2:0]      lvls [NSRC];
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] elig;
  logic            any_elig;
  logic            addr_ok;

  assign addr_ok = int'(reg_addr) < NSRC;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit;
    assign hit     = reg_wr && addr_ok && (int'(reg_addr) == g);
    assign elig[g] = flags[g] && (lvls[g] > cpu_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvls[g]  <= 3'd0;
        flags[g] <= 1'b0;
      end else begin
        if (hit) lvls[g] <= reg_wdata[2:0];
        if (src_req[g])
          flags[g] <= 1'b1;
        else if ((ack && irq && int'(win_idx) == g) || (hit && !reg_wdata[3]))
          flags[g] <= 1'b0;
      end
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      src_req[g] |=> flags[g]);
  end

  always_comb begin
    any_elig = 1'b0;
    win_idx  = '0;
    win_lvl  = 3'd0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!any_elig || lvls[i] > win_lvl)) begin
        any_elig = 1'b1;
        win_idx  = AW'(i);
        win_lvl  = lvls[i];
      end
    end
  end

  assign irq       = glb_en && any_elig;
  assign reg_rdata = addr_ok ? {4'b0000, flags[reg_addr], lvls[reg_addr]} : 8'h00;

  a_r4_one_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr_ok && reg_wdata[3] && !flags[reg_addr] && !src_req[reg_addr])
    |=> !flags[$past(reg_addr)]);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !src_req[win_idx]) |=> !flags[$past(win_idx)]);

  a_r5_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[win_idx] && lvls[win_idx] > cpu_lvl));

  a_r3_no_level0_win: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_lvl != 3'd0));

endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  localparam int N  = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] src_req = '0;
  logic glb_en = 0;
  logic [2:0] cpu_lvl = '0;
  logic ack = 0;
  logic irq;
  logic [AW-1:0] win_idx;
  logic [2:0] win_lvl;

  irq_level_arbiter #(.NSRC(N), .AW(AW)) u_irq_level_arbiter (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [2:0] m_lvl [N];
  logic [N-1:0] m_flag = '0;
  logic b_en = 0;
  logic [2:0] b_cpu = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model_win(output int idx, output int lv, output bit any);
    idx = 0; lv = 0; any = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_lvl[i] > b_cpu && (!any || m_lvl[i] > lv)) begin
        any = 1; idx = i; lv = m_lvl[i];
      end
  endfunction

  task automatic step(input logic [N-1:0] rq, input bit wr, input int ad,
                      input logic [7:0] wd, input bit ak);
    int ei, el; bit ea, ei_rq; logic eirq;
    @(negedge clk);
    src_req = rq; reg_wr = wr; reg_addr = AW'(ad); reg_wdata = wd; ack = ak;
    glb_en = b_en; cpu_lvl = b_cpu;
    #1;
    model_win(ei, el, ea);
    eirq = b_en && ea;
    chk(irq === eirq, "R5 irq", irq, eirq);
    chk(int'(win_idx) == ei, "R6 win_idx", win_idx, ei);
    chk(int'(win_lvl) == el, "R9 win_lvl", win_lvl, el);
    chk(reg_rdata === {4'b0, m_flag[ad], m_lvl[ad]}, "R2 rdata", reg_rdata,
        {4'b0, m_flag[ad], m_lvl[ad]});
    for (int i = 0; i < N; i++) begin
      if (wr && ad == i) m_lvl[i] = wd[2:0];
      if (rq[i]) m_flag[i] = 1;
      else if ((ak && eirq && ei == i) || (wr && ad == i && !wd[3])) m_flag[i] = 0;
    end
    @(posedge clk); #1;
    src_req = '0; reg_wr = 0; ack = 0;
  endtask

  task automatic rd(input int ad, input int exp, input string tag);
    step('0, 0, ad, 8'h00, 0);
    chk(int'(reg_rdata) == exp, tag, reg_rdata, exp);
  endtask

  task automatic expect_win(input bit eirq, input int ei, input int el, input string tag);
    @(negedge clk); glb_en = b_en; cpu_lvl = b_cpu; #1;
    chk(irq === eirq, tag, irq, eirq);
    if (eirq) chk(int'(win_idx) == ei && int'(win_lvl) == el, tag,
                  {win_idx, win_lvl}, ei * 8 + el);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_lvl[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 0; i < N; i++) rd(i, 0, "R1 reset reg");
    chk(irq === 1'b0, "R1 reset irq", irq, 0);

    // R2 upper bits ignored, R4 write of one does not set
    step('0, 1, 2, 8'hFF, 0);
    rd(2, 8'h07, "R2 R4 write FF");

    // R3 level-zero source with pending flag
    b_en = 1; b_cpu = 0;
    step(N'(1 << 5), 0, 0, 0, 0);
    rd(5, 8'h08, "R7 pulse sets flag");
    expect_win(0, 0, 0, "R3 level0 disabled");

    // R5 level against cpu level
    step('0, 1, 3, 8'h05, 0);
    step(N'(1 << 3), 0, 0, 0, 0);
    b_cpu = 5; expect_win(0, 0, 0, "R5 equal level blocked");
    b_cpu = 4; expect_win(1, 3, 5, "R5 above level accepted");
    b_en = 0;  expect_win(0, 0, 0, "R5 global enable off");
    chk(int'(win_idx) == 3 && win_lvl == 5, "R9 report without enable", win_idx, 3);
    b_en = 1;

    // R6 tie and higher level
    step('0, 1, 6, 8'h05, 0);
    step(N'(1 << 6), 0, 0, 0, 0);
    expect_win(1, 3, 5, "R6 tie lowest index");
    step('0, 1, 9, 8'h06, 0);
    step(N'(1 << 9), 0, 0, 0, 0);
    expect_win(1, 9, 6, "R6 higher level wins");

    // R8 acknowledge
    step('0, 0, 0, 0, 1);
    rd(9, 8'h06, "R8 ack clears winner");
    rd(3, 8'h0D, "R8 ack leaves others");
    b_cpu = 7;
    step('0, 0, 0, 0, 1);
    rd(3, 8'h0D, "R8 ack without irq ignored");
    b_cpu = 0;

    // R7 set beats clear, R4 clear by zero
    step(N'(1 << 3), 1, 3, 8'h05, 0);
    rd(3, 8'h0D, "R7 set beats clear");
    step('0, 1, 3, 8'h05, 0);
    rd(3, 8'h05, "R4 zero clears flag");

    // random traffic against model
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] rq;
      rq = N'($urandom & $urandom & $urandom & $urandom);
      b_en = ($urandom % 4) != 0;
      b_cpu = 3'($urandom);
      step(rq, ($urandom % 4) == 0, int'($urandom % N), 8'($urandom), ($urandom % 3) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule